// File: doc/BRIEF.md
# Run-Time Signed/Unsigned Multiplier Slice

This block is one multiplier slice. It either forms a single 18x18 product or two separate 9x9 products side by side. The width of the operation is fixed when the slice is built. Each operand carries its own sign flag, and the flags may change on any cycle. A high flag reads its operand as two's complement. A low flag reads it as a plain unsigned number. The result keeps every bit for every mix of signs, so nothing is truncated and nothing overflows.

Four paths can each be latched or passed straight through, chosen by a parameter and independently of one another: operand A, operand B, and the two sign flags. The result path can also be latched or passed through. When it is latched, the result register is split into two 18-bit sections in the dual-9x9 build and is one 36-bit section in the 18x18 build. Every register in the slice shares one clock, one clock enable and one asynchronous clear.

The slice has no valid/ready handshake. Data moves through whenever the clock enable is high and stalls whenever it is low, so a stream-side caller applies back-pressure by dropping the enable. Nothing is lost while the enable is low: every register keeps its contents, and the pass-through paths keep following their inputs.

Top module: `dsmul_slice`

## Requirements
- R1: With SPLIT=0, the output is the full 36-bit product of the two 18-bit operands, read according to the sign flags.
- R2: With SPLIT=1, lane 0 multiplies operand bits [8:0] and writes the product to result bits [17:0]. Lane 1 multiplies bits [17:9] and writes to bits [35:18]. Both lanes use the same two sign flags, and neither lane affects the other.
- R3: When sign_a_i is 1, operand A (or each lane slice of A) is a two's complement value; when it is 0, A is unsigned. sign_b_i sets the reading of operand B in the same way.
- R4: A mixed-sign product, with one operand signed and one unsigned, is signed and exact. The result is an unsigned number only when both flags are 0. The result is never truncated.
- R5: A path whose REG_* parameter is 1 adds exactly one enabled clock edge of delay. A path whose REG_* parameter is 0 is combinational.
- R6: While ce is 0, every register holds its value. Paths that are passed through still follow their inputs.
- R7: Raising aclr forces every register to zero at once, without waiting for a clock edge, and keeps it at zero while aclr stays high.
- R8: When both sign inputs are tied to 0, the slice performs plain unsigned multiplication.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by all registers in the slice |
| aclr | input | 1 | Asynchronous clear, active high |
| ce | input | 1 | Clock enable shared by all registers |
| a_i | input | 18 | Operand A |
| b_i | input | 18 | Operand B |
| sign_a_i | input | 1 | 1: A is two's complement, 0: A is unsigned |
| sign_b_i | input | 1 | 1: B is two's complement, 0: B is unsigned |
| p_o | output | 36 | Product; two 18-bit lane products when SPLIT=1 |

## Verification
How long a result takes to appear depends on the build. In the fully registered 18x18 build, a product appears two enabled clock edges after its operands and flags are applied. In the dual-9x9 build used by the bench, A and the B flag are latched and B, the A flag and the result pass straight through, so a change on B or on the A flag shows in the same cycle. A change on A or on the B flag shows after one enabled edge. The bench keeps one shadow register per latched path, which advances only on enabled edges and is zeroed by the clear, and it compares both builds on every falling clock edge, away from the capturing edge. The clear is also checked one nanosecond after it rises, before any clock edge, to show that it acts asynchronously.

// File: rtl/dsmul_pkg.sv
`timescale 1ns/1ps
package dsmul_pkg;
  // Operand width, lane width and derived sizes of one slice
  localparam int OP_W      = 18;
  localparam int LANE_W    = 9;
  localparam int NUM_LANES = OP_W / LANE_W;
  localparam int PROD_W    = 2 * OP_W;
  localparam int LANE_PW   = 2 * LANE_W;

  // Operand bundle after the optional input registers
  typedef struct packed {
    logic [OP_W-1:0] a;
    logic [OP_W-1:0] b;
    logic            sa;
    logic            sb;
  } dsmul_ops_t;
endpackage

// File: rtl/dsmul_pipe_reg.sv
`timescale 1ns/1ps
// One register stage that a parameter either keeps or removes (R5, R6, R7)
module dsmul_pipe_reg #(
  parameter int W  = 1,
  parameter bit EN = 1'b1
) (
  input  logic         clk,
  input  logic         aclr,
  input  logic         ce,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  generate
    if (EN) begin : g_reg
      logic [W-1:0] r;
      always_ff @(posedge clk or posedge aclr) begin
        if (aclr)    r <= '0;
        else if (ce) r <= d;
      end
      assign q = r;
    end else begin : g_thru
      logic unused_ctl;
      assign unused_ctl = ^{clk, aclr, ce};
      assign q = d;
    end
  endgenerate
endmodule

// File: rtl/dsmul_core.sv
`timescale 1ns/1ps
// Combinational multiplier array: one wide product or several lane products
module dsmul_core
  import dsmul_pkg::*;
#(
  parameter bit SPLIT = 1'b0
) (
  input  dsmul_ops_t        ops,
  output logic [PROD_W-1:0] p
);
  generate
    if (!SPLIT) begin : g_full
      // R1 R3 R4: extend each operand to full product width, then multiply
      logic [PROD_W-1:0] xa, xb;
      assign xa = {{(PROD_W-OP_W){ops.sa & ops.a[OP_W-1]}}, ops.a};
      assign xb = {{(PROD_W-OP_W){ops.sb & ops.b[OP_W-1]}}, ops.b};
      assign p  = xa * xb;
    end else begin : g_split
      // R2: independent lanes sharing the two sign flags
      for (genvar k = 0; k < NUM_LANES; k++) begin : g_lane
        logic [LANE_W-1:0]  la, lb;
        logic [LANE_PW-1:0] xa, xb;
        assign la = ops.a[k*LANE_W +: LANE_W];
        assign lb = ops.b[k*LANE_W +: LANE_W];
        assign xa = {{(LANE_PW-LANE_W){ops.sa & la[LANE_W-1]}}, la};
        assign xb = {{(LANE_PW-LANE_W){ops.sb & lb[LANE_W-1]}}, lb};
        assign p[k*LANE_PW +: LANE_PW] = xa * xb;
      end
    end
  endgenerate
endmodule

// File: rtl/dsmul_slice.sv
`timescale 1ns/1ps
module dsmul_slice
  import dsmul_pkg::*;
#(
  parameter bit SPLIT   = 1'b0,
  parameter bit REG_A   = 1'b1,
  parameter bit REG_B   = 1'b1,
  parameter bit REG_SA  = 1'b1,
  parameter bit REG_SB  = 1'b1,
  parameter bit REG_OUT = 1'b1
) (
  input  logic              clk,
  input  logic              aclr,
  input  logic              ce,
  input  logic [OP_W-1:0]   a_i,
  input  logic [OP_W-1:0]   b_i,
  input  logic              sign_a_i,
  input  logic              sign_b_i,
  output logic [PROD_W-1:0] p_o
);
  // Result register sections: one per lane in split mode, one otherwise
  localparam int N_SECT = SPLIT ? NUM_LANES : 1;
  localparam int SECT_W = PROD_W / N_SECT;

  logic [OP_W-1:0]   a_eff, b_eff;
  logic              sa_eff, sb_eff;
  logic [PROD_W-1:0] prod;
  dsmul_ops_t        ops;

  // R5: each input path has its own register-or-bypass choice
  dsmul_pipe_reg #(.W(OP_W), .EN(REG_A)) u_reg_a (
    .clk(clk), .aclr(aclr), .ce(ce), .d(a_i), .q(a_eff));
  dsmul_pipe_reg #(.W(OP_W), .EN(REG_B)) u_reg_b (
    .clk(clk), .aclr(aclr), .ce(ce), .d(b_i), .q(b_eff));
  dsmul_pipe_reg #(.W(1), .EN(REG_SA)) u_reg_sa (
    .clk(clk), .aclr(aclr), .ce(ce), .d(sign_a_i), .q(sa_eff));
  dsmul_pipe_reg #(.W(1), .EN(REG_SB)) u_reg_sb (
    .clk(clk), .aclr(aclr), .ce(ce), .d(sign_b_i), .q(sb_eff));

  assign ops = '{a: a_eff, b: b_eff, sa: sa_eff, sb: sb_eff};

  dsmul_core #(.SPLIT(SPLIT)) u_core (.ops(ops), .p(prod));

  generate
    for (genvar s = 0; s < N_SECT; s++) begin : g_osect
      dsmul_pipe_reg #(.W(SECT_W), .EN(REG_OUT)) u_reg_p (
        .clk(clk), .aclr(aclr), .ce(ce),
        .d(prod[s*SECT_W +: SECT_W]), .q(p_o[s*SECT_W +: SECT_W]));
    end
  endgenerate
endmodule

// File: rtl/dsmul_slice_chk.sv
`timescale 1ns/1ps
module dsmul_slice_chk
  import dsmul_pkg::*;
#(
  parameter bit SPLIT   = 1'b0,
  parameter bit REG_A   = 1'b1,
  parameter bit REG_B   = 1'b1,
  parameter bit REG_SA  = 1'b1,
  parameter bit REG_SB  = 1'b1,
  parameter bit REG_OUT = 1'b1
) (
  input logic              clk,
  input logic              aclr,
  input logic              ce,
  input logic [OP_W-1:0]   a_i,
  input logic [OP_W-1:0]   b_i,
  input logic              sign_a_i,
  input logic              sign_b_i,
  input logic [OP_W-1:0]   a_eff,
  input logic [OP_W-1:0]   b_eff,
  input logic              sa_eff,
  input logic              sb_eff,
  input logic [PROD_W-1:0] p_o
);
  localparam int IN_W = 2 * OP_W + 2;
  localparam logic [IN_W-1:0] REG_MASK =
    {{OP_W{REG_A}}, {OP_W{REG_B}}, REG_SA, REG_SB};

  logic [IN_W-1:0] raw, eff;
  assign raw = {a_i, b_i, sign_a_i, sign_b_i};
  assign eff = {a_eff, b_eff, sa_eff, sb_eff};

  // Sign-magnitude form of the expected product
  function automatic logic [PROD_W-1:0] ref_prod(
      input logic [OP_W-1:0] a, input logic [OP_W-1:0] b,
      input logic sa, input logic sb);
    logic [PROD_W-1:0] r;
    int w, nl;
    r  = '0;
    w  = SPLIT ? LANE_W : OP_W;
    nl = SPLIT ? NUM_LANES : 1;
    for (int k = 0; k < nl; k++) begin
      longint unsigned av, bv, mag;
      logic na, nb;
      av = (longint'(a) >> (k * w)) & ((64'd1 << w) - 64'd1);
      bv = (longint'(b) >> (k * w)) & ((64'd1 << w) - 64'd1);
      na = sa && av[w-1];
      nb = sb && bv[w-1];
      if (na) av = (64'd1 << w) - av;
      if (nb) bv = (64'd1 << w) - bv;
      mag = av * bv;
      if (na ^ nb) mag = -mag;
      mag = mag & ((64'd1 << (2 * w)) - 64'd1);
      r = r | PROD_W'(mag << (2 * w * k));
    end
    return r;
  endfunction

  generate
    if (REG_OUT) begin : g_oreg
      // R1 R2 R3 R4
      prod_match_chk: assert property (@(posedge clk) disable iff (aclr)
        ce |=> p_o == ref_prod($past(a_eff), $past(b_eff), $past(sa_eff), $past(sb_eff)));
      // R6
      out_hold_chk: assert property (@(posedge clk) disable iff (aclr)
        !ce |=> $stable(p_o));
    end else begin : g_othru
      always @(negedge clk) begin
        if (!aclr) begin
          // R1 R2 R3 R4
          prod_match_chk: assert (p_o == ref_prod(a_eff, b_eff, sa_eff, sb_eff));
        end
      end
    end
  endgenerate

  // R5
  in_capture_chk: assert property (@(posedge clk) disable iff (aclr)
    ce |=> ((eff ^ $past(raw)) & REG_MASK) == '0);

  // R6
  in_hold_chk: assert property (@(posedge clk) disable iff (aclr)
    !ce |=> ((eff ^ $past(eff)) & REG_MASK) == '0);

  always @(negedge clk) begin
    // R5
    in_bypass_chk: assert (((eff ^ raw) & ~REG_MASK) == '0);
    if (aclr) begin
      // R7
      clear_chk: assert (((eff & REG_MASK) == '0) && (!REG_OUT || p_o == '0));
    end
  end
endmodule

bind dsmul_slice dsmul_slice_chk #(
  .SPLIT(SPLIT), .REG_A(REG_A), .REG_B(REG_B),
  .REG_SA(REG_SA), .REG_SB(REG_SB), .REG_OUT(REG_OUT)
) u_chk (
  .clk(clk), .aclr(aclr), .ce(ce),
  .a_i(a_i), .b_i(b_i), .sign_a_i(sign_a_i), .sign_b_i(sign_b_i),
  .a_eff(a_eff), .b_eff(b_eff), .sa_eff(sa_eff), .sb_eff(sb_eff),
  .p_o(p_o)
);

// File: tb/dsmul_slice_tb.sv
`timescale 1ns/1ps
module dsmul_slice_tb;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        aclr = 1'b0;
  logic        ce = 1'b0;
  logic [17:0] a_in = '0, b_in = '0;
  logic        sa_in = 1'b0, sb_in = 1'b0;
  logic [35:0] p_full, p_split;

  int    checks = 0;
  int    fails  = 0;
  string tag    = "R7";

  // Fully registered 18x18 build
  dsmul_slice #(.SPLIT(1'b0), .REG_A(1'b1), .REG_B(1'b1), .REG_SA(1'b1),
                .REG_SB(1'b1), .REG_OUT(1'b1)) u_dut (
    .clk(clk), .aclr(aclr), .ce(ce), .a_i(a_in), .b_i(b_in),
    .sign_a_i(sa_in), .sign_b_i(sb_in), .p_o(p_full));

  // Dual 9x9 build with mixed register/bypass paths
  dsmul_slice #(.SPLIT(1'b1), .REG_A(1'b1), .REG_B(1'b0), .REG_SA(1'b0),
                .REG_SB(1'b1), .REG_OUT(1'b0)) u_dut_split (
    .clk(clk), .aclr(aclr), .ce(ce), .a_i(a_in), .b_i(b_in),
    .sign_a_i(sa_in), .sign_b_i(sb_in), .p_o(p_split));

  function automatic logic [35:0] mul_full(input logic [17:0] a, b, input logic sa, sb);
    longint va, vb, pr;
    va = sa ? longint'($signed(a)) : longint'(a);
    vb = sb ? longint'($signed(b)) : longint'(b);
    pr = va * vb;
    return pr[35:0];
  endfunction

  function automatic logic [17:0] mul_lane(input logic [8:0] a, b, input logic sa, sb);
    longint va, vb, pr;
    va = sa ? longint'($signed(a)) : longint'(a);
    vb = sb ? longint'($signed(b)) : longint'(b);
    pr = va * vb;
    return pr[17:0];
  endfunction

  // Reference model: shadow state for the latched paths only
  logic [17:0] m1_a = '0, m1_b = '0, m2_a = '0;
  logic        m1_sa = 1'b0, m1_sb = 1'b0, m2_sb = 1'b0;
  logic [35:0] m1_p = '0;

  always @(posedge clk or posedge aclr) begin
    if (aclr) begin
      m1_a <= '0; m1_b <= '0; m1_sa <= 1'b0; m1_sb <= 1'b0; m1_p <= '0;
      m2_a <= '0; m2_sb <= 1'b0;
    end else if (ce) begin
      m1_p  <= mul_full(m1_a, m1_b, m1_sa, m1_sb);
      m1_a  <= a_in; m1_b <= b_in; m1_sa <= sa_in; m1_sb <= sb_in;
      m2_a  <= a_in; m2_sb <= sb_in;
    end
  end

  task automatic compare();
    logic [35:0] e1, e2;
    e1 = m1_p;
    e2 = {mul_lane(m2_a[17:9], b_in[17:9], sa_in, m2_sb),
          mul_lane(m2_a[8:0],  b_in[8:0],  sa_in, m2_sb)};
    checks += 2;
    if (p_full !== e1) begin
      fails++;
      $display("FAIL %s u_dut t=%0t actual=%h expected=%h", tag, $time, p_full, e1);
    end
    if (p_split !== e2) begin
      fails++;
      $display("FAIL %s u_dut_split t=%0t actual=%h expected=%h", tag, $time, p_split, e2);
    end
  endtask

  always @(negedge clk) compare();

  task automatic step(input logic [17:0] av, bv, input logic s_a, s_b, c);
    @(posedge clk);
    #1;
    a_in = av; b_in = bv; sa_in = s_a; sb_in = s_b; ce = c;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #(5.0 * 150000);
    checks++;
    fails++;
    $display("FAIL watchdog (all requirements) actual=hung expected=finished");
    finish_run();
  end

  initial begin
    // R7: reset state, all outputs zero
    tag = "R7 reset";
    #1 aclr = 1'b1;
    repeat (3) @(posedge clk);
    #1 aclr = 1'b0;

    // R1 R8: unsigned full-precision products, signs tied low
    tag = "R1 R8";
    step(18'h3FFFF, 18'h3FFFF, 1'b0, 1'b0, 1'b1);
    step(18'h20000, 18'h00002, 1'b0, 1'b0, 1'b1);
    for (int i = 0; i < 20; i++)
      step(18'($urandom), 18'($urandom), 1'b0, 1'b0, 1'b1);

    // R3: both operands signed
    tag = "R3";
    step(18'h20000, 18'h20000, 1'b1, 1'b1, 1'b1);
    step(18'h3FFFF, 18'h3FFFF, 1'b1, 1'b1, 1'b1);
    step(18'h1FFFF, 18'h20000, 1'b1, 1'b1, 1'b1);
    for (int i = 0; i < 10; i++)
      step(18'($urandom), 18'($urandom), 1'b1, 1'b1, 1'b1);

    // R4: mixed signs, changing every cycle
    tag = "R4";
    step(18'h3FFFF, 18'h3FFFF, 1'b1, 1'b0, 1'b1);
    step(18'h3FFFF, 18'h3FFFF, 1'b0, 1'b1, 1'b1);
    step(18'h20000, 18'h3FFFF, 1'b1, 1'b0, 1'b1);
    for (int i = 0; i < 30; i++)
      step(18'($urandom), 18'($urandom), 1'($urandom), 1'($urandom), 1'b1);

    // R2: lane corners (lane 1 in bits 17:9, lane 0 in bits 8:0)
    tag = "R2";
    step({9'h100, 9'h0FF}, {9'h1FF, 9'h100}, 1'b1, 1'b1, 1'b1);
    step({9'h1FF, 9'h000}, {9'h1FF, 9'h1FF}, 1'b0, 1'b1, 1'b1);
    step({9'h000, 9'h1FF}, {9'h100, 9'h1FF}, 1'b1, 1'b0, 1'b1);
    step({9'h100, 9'h100}, {9'h100, 9'h100}, 1'b0, 1'b0, 1'b1);
    for (int i = 0; i < 10; i++)
      step(18'($urandom), 18'($urandom), 1'($urandom), 1'($urandom), 1'b1);

    // R5: one pulse of data through the registered and bypassed paths
    tag = "R5";
    step(18'h00005, 18'h00007, 1'b0, 1'b0, 1'b1);
    repeat (4) step('0, '0, 1'b0, 1'b0, 1'b1);

    // R6: clock enable toggling, registers must hold while low
    tag = "R6";
    for (int i = 0; i < 40; i++)
      step(18'($urandom), 18'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));

    // R7: asynchronous clear between clock edges
    tag = "R7 async";
    repeat (3) step(18'h12345, 18'h2ABCD, 1'b1, 1'b0, 1'b1);
    @(posedge clk);
    #1 aclr = 1'b1;
    #1 compare();
    @(posedge clk);
    #1 aclr = 1'b0;
    repeat (4) step(18'($urandom), 18'($urandom), 1'b1, 1'b1, 1'b1);

    @(posedge clk);
    @(negedge clk);
    #1 finish_run();
  end
endmodule